// File: doc/BRIEF.md
# Streaming Hamming Parity Generator for 256-Byte Chunks

This block watches the byte stream that flows through a NAND flash data path. It builds a single-error-correcting Hamming parity code over each chunk of 256 accepted bytes. Every byte adds to a set of column parities and a set of line parities. Column parities cover the bit positions inside the byte. Line parities cover the index of the byte inside the chunk. After the last byte of a chunk, the block stores the finished parity word, resets its running state for the next chunk, and pulses a completion flag for one clock.

The stored word is always visible as a 32-bit raw value. The same value is also presented in its spare-area form, which is three bytes. To build that form, the raw word is shifted up by two places, inverted, and cut to 24 bits. The three bytes are then emitted most significant first. Software, or a transfer engine, saves the three bytes of each chunk next to the data. On a later read it compares them with a freshly computed set to find and repair one flipped bit.

The byte input follows valid/ready rules, but the block never applies back-pressure. `in_ready` is always high, so a byte is consumed in every cycle where `in_valid` is high. Whether that byte counts toward the parity depends only on `en` and `clr` in that cycle. A byte presented while `en` is low, or in a cycle with `clr`, is consumed and discarded.

Top module: `ecc256_stream_gen`

## Requirements
- R1: After reset `parity_raw` is 0, `chunk_done` is 0, and the three code bytes read 0xFF, 0xFF, 0xFF.
- R2: In the raw word, bit 2j (j = 0..2) is the XOR over the chunk of every data bit whose bit position has bit j clear. Bit 2j+1 is the same XOR over every data bit whose position has bit j set.
- R3: In the raw word, bit 6+2k (k = 0..7) is the XOR of all bits of every byte whose chunk index has bit k clear. Bit 7+2k is the same XOR for bytes whose index has bit k set. Bits 31:22 are zero.
- R4: Each chunk is computed independently. On the clock edge that accepts the 256th byte, `parity_raw` takes that chunk's word and `chunk_done` is high for exactly one cycle. `parity_raw` then holds until the next completion or clear.
- R5: A byte is accepted only in a cycle with `en` high and `in_valid` high. Idle cycles and cycles with `en` low neither change the parity nor advance the byte count.
- R6: `clr` zeroes the running parity, the byte count, `parity_raw` and `chunk_done`. A byte offered in the same cycle is dropped, including a byte that would have completed a chunk.
- R7: The code is the inverse of (`parity_raw` shifted left by 2), truncated to 24 bits. `ecc_b0` = code[23:16], `ecc_b1` = code[15:8], `ecc_b2` = code[7:0]. The two low bits of `ecc_b2` are therefore 1.
- R8: Take two chunks that differ in exactly one data bit and XOR their codes. The result has exactly 11 bits set. Code bits 7, 5, 3 give the flipped bit position (MSB first). Code bits 9+2k give bit k of the byte index.
- R9: `in_ready` is 1 in every cycle, including cycles with `clr` or with `en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Accumulation enable |
| clr | input | 1 | Clear pulse; wins over a same-cycle byte |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready, tied high |
| in_data | input | 8 | Byte stream data |
| parity_raw | output | 32 | Stored parity word of the last completed chunk |
| ecc_b0 | output | 8 | Code bits 23:16 |
| ecc_b1 | output | 8 | Code bits 15:8 |
| ecc_b2 | output | 8 | Code bits 7:0 |
| chunk_done | output | 1 | One-cycle pulse after a chunk's final byte |

## Verification
Clear and byte acceptance can land in the same cycle, and the hardest case is a clear that arrives together with the byte that would complete a chunk. The bench causes this in two ways. First, it raises `clr` with `in_valid` and `en` high partway through a chunk. Second, it raises `clr` on the 256th byte of a chunk. In both cases it expects no completion pulse and a zero stored word. It then feeds one more full chunk and expects the result to match a chunk computed from scratch. This proves that neither the dropped byte nor the earlier partial sums leaked into it.

// File: rtl/ecc256_pkg.sv
package ecc256_pkg;

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned BITSEL_W   = $clog2(BYTE_W);
  localparam int unsigned COL_W      = 2 * BITSEL_W;
  localparam int unsigned RAW_W      = 32;
  localparam int unsigned CODE_W     = 24;
  localparam int unsigned CODE_SHIFT = 2;
  localparam int unsigned CODE_BYTES = CODE_W / BYTE_W;

  typedef logic [BYTE_W-1:0] data_byte_t;

  // One operation per cycle; clear outranks taking a byte.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_TAKE  = 2'd1,
    OP_CLEAR = 2'd2
  } acc_op_e;

  // Mask of byte bit positions whose index has bit j set.
  function automatic data_byte_t hi_sel_mask(input int unsigned j);
    data_byte_t m;
    m = '0;
    for (int b = 0; b < int'(BYTE_W); b++) begin
      m[b] = ((b >> j) & 1) == 1;
    end
    return m;
  endfunction

endpackage

// File: rtl/ecc256_col_parity.sv
module ecc256_col_parity
  import ecc256_pkg::*;
(
  input  data_byte_t       din,
  output logic [COL_W-1:0] col,
  output logic             row
);

  generate
    for (genvar j = 0; j < int'(BITSEL_W); j++) begin : g_sel
      localparam data_byte_t HI = hi_sel_mask(j);
      assign col[2*j]   = ^(din & ~HI);
      assign col[2*j+1] = ^(din & HI);
    end
  endgenerate

  assign row = ^din;

endmodule

// File: rtl/ecc256_accum.sv
module ecc256_accum
  import ecc256_pkg::*;
#(
  parameter int unsigned CHUNK_BYTES = 256,
  localparam int unsigned IDX_W  = $clog2(CHUNK_BYTES),
  localparam int unsigned LINE_W = 2 * IDX_W,
  localparam int unsigned WORD_W = COL_W + LINE_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_op_e           op,
  input  logic [COL_W-1:0]  col_in,
  input  logic              row_in,
  output logic [WORD_W-1:0] word_next,
  output logic              last
);

  logic [COL_W-1:0]  col_q, col_nx;
  logic [LINE_W-1:0] line_q, line_nx;
  logic [IDX_W-1:0]  idx_q;

  assign col_nx = col_q ^ col_in;

  generate
    for (genvar k = 0; k < int'(IDX_W); k++) begin : g_line
      assign line_nx[2*k]   = line_q[2*k]   ^ (row_in & ~idx_q[k]);
      assign line_nx[2*k+1] = line_q[2*k+1] ^ (row_in &  idx_q[k]);
    end
  endgenerate

  assign last      = (idx_q == IDX_W'(CHUNK_BYTES - 1));
  assign word_next = {line_nx, col_nx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      line_q <= '0;
      idx_q  <= '0;
    end else begin
      unique case (op)
        OP_CLEAR: begin
          col_q  <= '0;
          line_q <= '0;
          idx_q  <= '0;
        end
        OP_TAKE: begin
          idx_q <= idx_q + 1'b1;
          if (last) begin
            col_q  <= '0;
            line_q <= '0;
          end else begin
            col_q  <= col_nx;
            line_q <= line_nx;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ecc256_result.sv
module ecc256_result
  import ecc256_pkg::*;
#(
  parameter int unsigned WORD_W = 22
)(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_op_e           op,
  input  logic              last,
  input  logic [WORD_W-1:0] word_next,
  output logic [RAW_W-1:0]  raw,
  output logic              done
);

  localparam int unsigned PAD_W = RAW_W - WORD_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (op)
        OP_CLEAR: raw <= '0;
        OP_TAKE: if (last) begin
          raw  <= {{PAD_W{1'b0}}, word_next};
          done <= 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ecc256_code_fmt.sv
module ecc256_code_fmt
  import ecc256_pkg::*;
(
  input  logic [RAW_W-1:0]                   raw,
  output logic [CODE_BYTES-1:0][BYTE_W-1:0]  code_bytes
);

  logic [RAW_W-1:0]  shifted;
  logic [CODE_W-1:0] code;

  assign shifted = raw << CODE_SHIFT;
  assign code    = ~shifted[CODE_W-1:0];

  generate
    for (genvar g = 0; g < int'(CODE_BYTES); g++) begin : g_byte
      assign code_bytes[g] = code[CODE_W-1-g*BYTE_W -: BYTE_W];
    end
  endgenerate

endmodule

// File: rtl/ecc256_stream_gen.sv
module ecc256_stream_gen
  import ecc256_pkg::*;
#(
  parameter int unsigned CHUNK_BYTES = 256
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        clr,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  output logic [31:0] parity_raw,
  output logic [7:0]  ecc_b0,
  output logic [7:0]  ecc_b1,
  output logic [7:0]  ecc_b2,
  output logic        chunk_done
);

  localparam int unsigned IDX_W  = $clog2(CHUNK_BYTES);
  localparam int unsigned WORD_W = COL_W + 2 * IDX_W;

  acc_op_e                           op;
  logic [COL_W-1:0]                  col_bits;
  logic                              row_bit;
  logic [WORD_W-1:0]                 word_next;
  logic                              last;
  logic [CODE_BYTES-1:0][BYTE_W-1:0] code_bytes;

  always_comb begin
    if (clr)                 op = OP_CLEAR;
    else if (en && in_valid) op = OP_TAKE;
    else                     op = OP_HOLD;
  end

  assign in_ready = 1'b1;

  ecc256_col_parity u_col (
    .din (in_data),
    .col (col_bits),
    .row (row_bit)
  );

  ecc256_accum #(.CHUNK_BYTES(CHUNK_BYTES)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .col_in    (col_bits),
    .row_in    (row_bit),
    .word_next (word_next),
    .last      (last)
  );

  ecc256_result #(.WORD_W(WORD_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .last      (last),
    .word_next (word_next),
    .raw       (parity_raw),
    .done      (chunk_done)
  );

  ecc256_code_fmt u_fmt (
    .raw        (parity_raw),
    .code_bytes (code_bytes)
  );

  assign ecc_b0 = code_bytes[0];
  assign ecc_b1 = code_bytes[1];
  assign ecc_b2 = code_bytes[2];

endmodule

// File: rtl/ecc256_stream_gen_chk.sv
module ecc256_stream_gen_chk #(
  parameter int unsigned CHUNK_BYTES = 256
)(
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        clr,
  input logic        in_valid,
  input logic        chunk_done,
  input logic [31:0] parity_raw
);

  localparam int unsigned CW = $clog2(CHUNK_BYTES);

  logic [CW-1:0] seen_q;
  logic          fin_q;

  // Independent count of accepted bytes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      fin_q  <= 1'b0;
    end else if (clr) begin
      seen_q <= '0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (en && in_valid) begin
        seen_q <= seen_q + 1'b1;
        fin_q  <= (seen_q == CW'(CHUNK_BYTES - 1));
      end
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done |=> !chunk_done);

  assert_done_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_done == fin_q);

  assert_raw_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(parity_raw) |-> (chunk_done || $past(clr)));

  assert_clr_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!chunk_done && parity_raw == 32'd0));

  assert_no_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || !in_valid) |=> !chunk_done);

endmodule

bind ecc256_stream_gen ecc256_stream_gen_chk #(.CHUNK_BYTES(CHUNK_BYTES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .clr        (clr),
  .in_valid   (in_valid),
  .chunk_done (chunk_done),
  .parity_raw (parity_raw)
);

// File: tb/ecc256_stream_gen_tb_top.sv
module ecc256_stream_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n, en, clr, in_valid;
  logic [7:0]  in_data;
  logic        in_ready, chunk_done;
  logic [31:0] parity_raw;
  logic [7:0]  ecc_b0, ecc_b1, ecc_b2;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  ecc256_stream_gen dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .parity_raw(parity_raw), .ecc_b0(ecc_b0), .ecc_b1(ecc_b1),
    .ecc_b2(ecc_b2), .chunk_done(chunk_done)
  );

  // Stimulus table: {mul, add, xor, flags}; flags bit0 inserts gaps.
  localparam logic [31:0] VTAB [0:7] = '{
    32'h00_00_00_00, 32'h00_00_FF_00, 32'h01_00_00_00, 32'h03_11_00_01,
    32'h00_A5_00_00, 32'h07_3C_5A_01, 32'h0D_00_80_00, 32'hC5_21_0F_01
  };

  function automatic logic [7:0] pat(logic [7:0] mul, logic [7:0] add,
                                     logic [7:0] xr, int i);
    return 8'((i * int'(mul)) + int'(add)) ^ xr;
  endfunction

  // Expected raw word from R2/R3, bit by bit.
  function automatic logic [31:0] model(logic [7:0] mul, logic [7:0] add,
                                        logic [7:0] xr, int fi, int fb);
    logic [31:0] r;
    logic [7:0]  d;
    r = '0;
    for (int i = 0; i < 256; i++) begin
      d = pat(mul, add, xr, i);
      if (i == fi) d[fb] = ~d[fb];
      for (int b = 0; b < 8; b++) begin
        if (d[b]) begin
          for (int j = 0; j < 3; j++) r[2*j + ((b >> j) & 1)] ^= 1'b1;
          for (int k = 0; k < 8; k++) r[6 + 2*k + ((i >> k) & 1)] ^= 1'b1;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [23:0] code_of(logic [31:0] r);
    logic [31:0] s;
    s = r << 2;
    return ~s[23:0];
  endfunction

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic push(logic [7:0] d, logic with_clr);
    in_valid = 1'b1;
    in_data  = d;
    clr      = with_clr;
    @(negedge clk);
    in_valid = 1'b0;
    clr      = 1'b0;
  endtask

  // Feeds one chunk; afterwards the negedge after the final byte is current.
  task automatic run_chunk(logic [7:0] mul, logic [7:0] add, logic [7:0] xr,
                           int fi, int fb, bit gaps, string tag);
    logic [7:0]  d;
    logic [31:0] exp;
    bit          early;
    early = 0;
    for (int i = 0; i < 256; i++) begin
      if (gaps && (i % 37) == 5) @(negedge clk);
      if (gaps && (i % 53) == 7) begin
        en = 1'b0; in_valid = 1'b1; in_data = 8'h5C;
        @(negedge clk);
        if (chunk_done) early = 1;
        en = 1'b1; in_valid = 1'b0;
      end
      d = pat(mul, add, xr, i);
      if (i == fi) d[fb] = ~d[fb];
      push(d, 1'b0);
      if (i < 255 && chunk_done) early = 1;
    end
    exp = model(mul, add, xr, fi, fb);
    chk({tag, " R4 done on 256th"}, 32'(chunk_done), 32'd1);
    chk({tag, " R2 R3 raw"}, parity_raw, exp);
    chk({tag, " R7 code bytes"}, {8'h0, ecc_b0, ecc_b1, ecc_b2}, {8'h0, code_of(exp)});
    chk({tag, " R4 R5 no early done"}, 32'(early), 32'd0);
    @(negedge clk);
    chk({tag, " R4 one-cycle done"}, 32'(chunk_done), 32'd0);
    chk({tag, " R4 raw held"}, parity_raw, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    logic [23:0] ca, cb, x;
    logic [7:0]  bidx;
    logic [31:0] held;
    rst_n = 1'b0; en = 1'b1; clr = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 raw after reset", parity_raw, 32'd0);
    chk("R1 code after reset", {8'h0, ecc_b0, ecc_b1, ecc_b2}, 32'h00FF_FFFF);
    chk("R1 done after reset", 32'(chunk_done), 32'd0);
    chk("R9 ready", 32'(in_ready), 32'd1);

    for (int v = 0; v < 8; v++)
      run_chunk(VTAB[v][31:24], VTAB[v][23:16], VTAB[v][15:8], -1, 0,
                VTAB[v][0], $sformatf("vec%0d", v));

    // R8: single flipped bit located from code difference.
    run_chunk(8'h01, 8'h00, 8'h00, -1, 0, 1'b0, "R8 base");
    ca = {ecc_b0, ecc_b1, ecc_b2};
    run_chunk(8'h01, 8'h00, 8'h00, 8'hA5, 6, 1'b0, "R8 flip");
    cb = {ecc_b0, ecc_b1, ecc_b2};
    x  = ca ^ cb;
    chk("R8 bits set", 32'($countones(x)), 32'd11);
    chk("R8 bit position", 32'({x[7], x[5], x[3]}), 32'd6);
    for (int k = 0; k < 8; k++) bidx[k] = x[9 + 2*k];
    chk("R8 byte index", 32'(bidx), 32'hA5);

    // R6: clear with a byte mid-chunk.
    for (int i = 0; i < 100; i++) push(8'(i * 7), 1'b0);
    en = 1'b1;
    push(8'hE7, 1'b1);
    chk("R6 raw zeroed by clr", parity_raw, 32'd0);
    chk("R9 ready around clr", 32'(in_ready), 32'd1);
    run_chunk(8'h07, 8'h3C, 8'h5A, -1, 0, 1'b0, "R6 after mid clr");

    // R6: clear on the completing byte.
    for (int i = 0; i < 255; i++) push(pat(8'h0D, 8'h00, 8'h80, i), 1'b0);
    push(pat(8'h0D, 8'h00, 8'h80, 255), 1'b1);
    chk("R6 clr drops completion", 32'(chunk_done), 32'd0);
    chk("R6 clr on last raw", parity_raw, 32'd0);
    run_chunk(8'h0D, 8'h00, 8'h80, -1, 0, 1'b0, "R6 after last clr");

    // R5: enable low for a long stream.
    held = parity_raw;
    en = 1'b0;
    for (int i = 0; i < 300; i++) push(8'(i), 1'b0);
    chk("R5 disabled no done", 32'(chunk_done), 32'd0);
    chk("R5 disabled raw held", parity_raw, held);
    chk("R9 ready while disabled", 32'(in_ready), 32'd1);
    en = 1'b1;
    run_chunk(8'hC5, 8'h21, 8'h0F, -1, 0, 1'b0, "R5 after disable");

    summary();
  end

endmodule